// File: doc/BRIEF.md
# Inversionless Error-Locator Solver for Binary BCH Codes

This block turns the syndromes of a binary BCH codeword into the error-locator polynomial. It uses the simplified, inversionless form of the Berlekamp-Massey recurrence over GF(2^14). For binary codes every second discrepancy is zero, so the solver needs only t iterations rather than 2t. No field inversion appears anywhere. Each iteration takes one clock. Every locator coefficient and the discrepancy sum have their own GF multipliers, so all of them are updated in parallel.

The correction strength is chosen per codeword: 8, 16 or 32 errors. A weaker code runs fewer iterations and keeps the unused upper coefficients at zero. The caller presents a full syndrome vector and a mode and pulses a start input. When the done output rises, the locator coefficients and the locator degree are valid. A later root search is built from constant multipliers and uses these coefficients. It can flag an uncorrectable block when its root count differs from the reported degree.

Top module: `sibm_solver`

## Requirements
- R1: While reset is high and on the first edge after it, `done_o` is 0, `lambda_o` holds coefficient 0 equal to 1 with all other coefficients 0, and `deg_o` is 0.
- R2: A start is accepted on an edge where `start_i` is 1 and no solve is running. The mode is captured on that edge. Mode 0 selects t=8, mode 1 selects t=16, and modes 2 and 3 select t=32.
- R3: `done_o` becomes 1 exactly t rising edges after the edge that accepted the start.
- R4: Syndrome S_i (i = 1..64) sits at `synd_i[14(i-1)+13 : 14(i-1)]`, and coefficient j sits at `lambda_o[14j+13 : 14j]`. The field is built on x^14+x^5+x^3+x+1 with alpha = 2. For nu <= t distinct error locators X, where S_i = XOR of X^i, the output satisfies lambda = c * prod(1 + X x) with a nonzero scale c, so coefficient 0 is never zero.
- R5: `deg_o` is the highest index of a nonzero coefficient, which is nu for a correctable pattern, and it never exceeds t.
- R6: When done, every coefficient with index above t is zero.
- R7: Syndromes with index above 2t have no effect on the result.
- R8: While a solve is running, `start_i`, `mode_i` and `synd_i` have no effect on the result or on the completion time.
- R9: Once done, the outputs hold until the next accepted start. A start accepted while done clears `done_o` on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a solve with the present syndromes and mode |
| mode_i | input | 2 | Correction strength select (0:8, 1:16, 2/3:32) |
| synd_i | input | 896 | Syndromes S1..S64, 14 bits each, S1 in the low bits |
| done_o | output | 1 | Result valid, held until the next accepted start |
| lambda_o | output | 462 | Locator coefficients 0..32, 14 bits each, coefficient 0 in the low bits |
| deg_o | output | 6 | Degree of the locator |

## Verification
A new start request can arrive on the same edge that performs the final iteration. The block must ignore that request, because it is still running, and still finish the iteration and raise done. The bench holds start high across that last iteration edge. It then checks that done rises at the nominal time with the correct polynomial, and that done stays high on the next edge. A second collision, a start while done is high, is judged by done dropping on the accepting edge and the new result arriving t edges later.

// File: rtl/sibm_pkg.sv
`timescale 1ns/1ps
package sibm_pkg;

    localparam int GF_M = 14;
    localparam logic [GF_M:0] GF_POLY = 15'h402B;

    typedef logic [GF_M-1:0] gf_t;

    localparam gf_t GF_ONE = gf_t'(1);

    typedef enum logic [1:0] {
        CAP_LOW  = 2'd0,
        CAP_MID  = 2'd1,
        CAP_HIGH = 2'd2,
        CAP_ALT  = 2'd3
    } cap_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    // Shift-and-add product with reduction on every shift.
    function automatic gf_t gf_mul(gf_t a, gf_t b);
        gf_t acc;
        gf_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < GF_M; i++) begin
            if (b[i]) acc = acc ^ sh;
            if (sh[GF_M-1]) sh = (sh << 1) ^ GF_POLY[GF_M-1:0];
            else            sh = sh << 1;
        end
        return acc;
    endfunction

    // Correction capability for a mode code, clamped to the build limit.
    function automatic int cap_to_t(cap_e c, int t_max);
        int t;
        case (c)
            CAP_LOW: t = 8;
            CAP_MID: t = 16;
            default: t = 32;
        endcase
        return (t > t_max) ? t_max : t;
    endfunction

endpackage

// File: rtl/sibm_synd_window.sv
`timescale 1ns/1ps
// Holds the syndromes and presents, for iteration r, the term S(2r+1-j)
// next to coefficient j. The queue advances by two per iteration.
module sibm_synd_window
    import sibm_pkg::*;
#(
    parameter int T_MAX = 32,
    parameter int TW    = $clog2(T_MAX + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load,
    input  logic                        step,
    input  logic [TW-1:0]               t_sel,
    input  logic [2*T_MAX*GF_M-1:0]     synd_flat,
    output logic [(T_MAX+1)*GF_M-1:0]   win_flat
);
    localparam int NQ = 2 * T_MAX;
    localparam int IW = TW + 1;

    gf_t q_q [0:NQ-1];
    gf_t w_q [1:T_MAX];

    logic [IW-1:0] lim;
    assign lim = {t_sel, 1'b0};

    for (genvar i = 0; i < NQ; i++) begin : g_queue
        localparam logic [IW-1:0] IDX = IW'(i);
        gf_t adv;
        if (i + 2 < NQ) begin : g_mid
            assign adv = q_q[i+2];
        end else begin : g_end
            assign adv = '0;
        end
        always_ff @(posedge clk) begin
            if (rst)       q_q[i] <= '0;
            else if (load) q_q[i] <= (IDX < lim) ? synd_flat[i*GF_M +: GF_M] : '0;
            else if (step) q_q[i] <= adv;
        end
    end

    for (genvar j = 1; j <= T_MAX; j++) begin : g_win
        gf_t nxt;
        if (j == 1) begin : g_a
            assign nxt = q_q[1];
        end else if (j == 2) begin : g_b
            assign nxt = q_q[0];
        end else begin : g_c
            assign nxt = w_q[j-2];
        end
        always_ff @(posedge clk) begin
            if (rst || load) w_q[j] <= '0;
            else if (step)   w_q[j] <= nxt;
        end
        assign win_flat[j*GF_M +: GF_M] = w_q[j];
    end

    assign win_flat[GF_M-1:0] = q_q[0];

endmodule

// File: rtl/sibm_discrepancy.sv
`timescale 1ns/1ps
// Discrepancy: sum over j of Lambda_j * S(2r+1-j).
module sibm_discrepancy
    import sibm_pkg::*;
#(
    parameter int T_MAX = 32
) (
    input  logic [(T_MAX+1)*GF_M-1:0] lam_flat,
    input  logic [(T_MAX+1)*GF_M-1:0] win_flat,
    output gf_t                       delta
);
    always_comb begin
        delta = '0;
        for (int j = 0; j <= T_MAX; j++) begin
            delta = delta ^ gf_mul(lam_flat[j*GF_M +: GF_M], win_flat[j*GF_M +: GF_M]);
        end
    end
endmodule

// File: rtl/sibm_poly_update.sv
`timescale 1ns/1ps
// Locator, correction polynomial, scale and step counter registers.
module sibm_poly_update
    import sibm_pkg::*;
#(
    parameter int T_MAX = 32,
    parameter int TW    = $clog2(T_MAX + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic                      step,
    input  logic [TW-1:0]             t_sel,
    input  gf_t                       delta,
    output logic [(T_MAX+1)*GF_M-1:0] lam_flat
);
    localparam int KW = $clog2(2 * T_MAX + 1) + 2;

    gf_t lam_q [0:T_MAX];
    gf_t b_q   [0:T_MAX];
    gf_t lam_d [0:T_MAX];
    gf_t b_d   [0:T_MAX];
    gf_t gamma_q;
    logic signed [KW-1:0] k_q;
    logic swap;

    assign swap = (delta != '0) && !k_q[KW-1];

    for (genvar j = 0; j <= T_MAX; j++) begin : g_coef
        localparam logic [TW-1:0] JIDX = TW'(j);
        logic keep;
        gf_t from_b;
        gf_t grow_src;
        gf_t shift_src;
        assign keep = (JIDX <= t_sel);
        if (j == 0) begin : g_j0
            assign from_b    = '0;
            assign grow_src  = '0;
            assign shift_src = '0;
        end else if (j == 1) begin : g_j1
            assign from_b    = b_q[0];
            assign grow_src  = lam_q[0];
            assign shift_src = '0;
        end else begin : g_jn
            assign from_b    = b_q[j-1];
            assign grow_src  = lam_q[j-1];
            assign shift_src = b_q[j-2];
        end
        assign lam_d[j] = keep ? (gf_mul(gamma_q, lam_q[j]) ^ gf_mul(delta, from_b)) : '0;
        assign b_d[j]   = keep ? (swap ? grow_src : shift_src) : '0;
        assign lam_flat[j*GF_M +: GF_M] = lam_q[j];
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            for (int j = 0; j <= T_MAX; j++) begin
                lam_q[j] <= (j == 0) ? GF_ONE : '0;
                b_q[j]   <= (j == 0) ? GF_ONE : '0;
            end
            gamma_q <= GF_ONE;
            k_q     <= '0;
        end else if (step) begin
            lam_q <= lam_d;
            b_q   <= b_d;
            if (swap) begin
                gamma_q <= delta;
                k_q     <= -k_q;
            end else begin
                k_q <= k_q + KW'(2);
            end
        end
    end
endmodule

// File: rtl/sibm_solver.sv
`timescale 1ns/1ps
module sibm_solver
    import sibm_pkg::*;
#(
    parameter int T_MAX = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start_i,
    input  logic [1:0]                   mode_i,
    input  logic [2*T_MAX*GF_M-1:0]      synd_i,
    output logic                         done_o,
    output logic [(T_MAX+1)*GF_M-1:0]    lambda_o,
    output logic [$clog2(T_MAX+1)-1:0]   deg_o
);
    localparam int TW = $clog2(T_MAX + 1);

    phase_e          ph_q;
    logic [TW-1:0]   it_q;
    logic [TW-1:0]   t_q;
    logic [TW-1:0]   t_new;
    logic [TW-1:0]   t_use;
    logic            accept;
    logic            step;
    gf_t             delta;
    logic [(T_MAX+1)*GF_M-1:0] win;
    logic [(T_MAX+1)*GF_M-1:0] lam;

    assign accept = start_i && (ph_q != PH_RUN);
    assign step   = (ph_q == PH_RUN);
    assign t_new  = TW'(cap_to_t(cap_e'(mode_i), T_MAX));
    assign t_use  = accept ? t_new : t_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_IDLE;
            it_q <= '0;
            t_q  <= TW'(T_MAX);
        end else if (accept) begin
            ph_q <= PH_RUN;
            it_q <= '0;
            t_q  <= t_new;
        end else if (step) begin
            it_q <= it_q + 1'b1;
            if (it_q == t_q - 1'b1) ph_q <= PH_DONE;
        end
    end

    sibm_synd_window #(.T_MAX(T_MAX), .TW(TW)) u_win (
        .clk(clk), .rst(rst), .load(accept), .step(step),
        .t_sel(t_use), .synd_flat(synd_i), .win_flat(win)
    );

    sibm_discrepancy #(.T_MAX(T_MAX)) u_disc (
        .lam_flat(lam), .win_flat(win), .delta(delta)
    );

    sibm_poly_update #(.T_MAX(T_MAX), .TW(TW)) u_upd (
        .clk(clk), .rst(rst), .load(accept), .step(step),
        .t_sel(t_use), .delta(delta), .lam_flat(lam)
    );

    always_comb begin
        deg_o = '0;
        for (int j = 0; j <= T_MAX; j++) begin
            if (lam[j*GF_M +: GF_M] != '0) deg_o = TW'(j);
        end
    end

    assign lambda_o = lam;
    assign done_o   = (ph_q == PH_DONE);

endmodule

// File: rtl/sibm_solver_chk.sv
`timescale 1ns/1ps
module sibm_solver_chk
    import sibm_pkg::*;
#(
    parameter int T_MAX = 32
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        start_i,
    input logic [1:0]                  mode_i,
    input logic                        done_o,
    input logic [(T_MAX+1)*GF_M-1:0]   lambda_o,
    input logic [$clog2(T_MAX+1)-1:0]  deg_o
);
    localparam int TW = $clog2(T_MAX + 1);

    logic          c_run;
    logic [TW:0]   c_cnt;
    logic [TW-1:0] c_t;
    logic          hi_nz;
    gf_t           lead;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_run <= 1'b0;
            c_cnt <= '0;
            c_t   <= TW'(T_MAX);
        end else if (start_i && (!c_run || done_o)) begin
            c_run <= 1'b1;
            c_cnt <= '0;
            c_t   <= TW'(cap_to_t(cap_e'(mode_i), T_MAX));
        end else if (c_run && !done_o) begin
            c_cnt <= c_cnt + 1'b1;
        end
    end

    always_comb begin
        hi_nz = 1'b0;
        lead  = '0;
        for (int j = 0; j <= T_MAX; j++) begin
            if ((TW'(j) > c_t) && (lambda_o[j*GF_M +: GF_M] != '0)) hi_nz = 1'b1;
            if (TW'(j) == deg_o) lead = lambda_o[j*GF_M +: GF_M];
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> !done_o); // R1

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> (c_run && (c_cnt == {1'b0, c_t}))); // R3

    AST_LEAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (lambda_o[GF_M-1:0] != '0)); // R4

    AST_DEG_POINTS_NONZERO: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ((deg_o <= c_t) && ((deg_o == '0) || (lead != '0)))); // R5

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !hi_nz); // R6

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> (done_o && $stable(lambda_o) && $stable(deg_o))); // R9

    AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (done_o && start_i) |=> !done_o); // R9

endmodule

bind sibm_solver sibm_solver_chk #(.T_MAX(T_MAX)) u_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
    .done_o(done_o), .lambda_o(lambda_o), .deg_o(deg_o)
);

// File: tb/sim_sibm_solver.sv
`timescale 1ns/1ps
module sim_sibm_solver;
    import sibm_pkg::*;

    localparam int T_MAX = 32;
    localparam int M     = GF_M;
    localparam int SW    = 2 * T_MAX * M;
    localparam int LW    = (T_MAX + 1) * M;
    localparam int DW    = $clog2(T_MAX + 1);
    localparam int ORD   = (1 << M) - 1;

    // {mode, error count, first position, position step}
    localparam logic [35:0] VEC [0:8] = '{
        {2'd0, 6'd0,  14'd0,    14'd0},
        {2'd0, 6'd1,  14'd5,    14'd0},
        {2'd0, 6'd8,  14'd100,  14'd977},
        {2'd1, 6'd16, 14'd3,    14'd511},
        {2'd2, 6'd32, 14'd7,    14'd257},
        {2'd2, 6'd20, 14'd8000, 14'd13},
        {2'd1, 6'd5,  14'd1234, 14'd1000},
        {2'd3, 6'd32, 14'd1,    14'd269},
        {2'd0, 6'd3,  14'd8637, 14'd1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [SW-1:0] synd = '0;
    logic done;
    logic [LW-1:0] lam;
    logic [DW-1:0] deg;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    gf_t ep [0:T_MAX];

    sibm_solver #(.T_MAX(T_MAX)) u0 (
        .clk(clk), .rst(rst), .start_i(start), .mode_i(mode),
        .synd_i(synd), .done_o(done), .lambda_o(lam), .deg_o(deg)
    );

    always #10 clk = ~clk;

    function automatic gf_t tb_mul(gf_t a, gf_t b);
        logic [2*M-2:0] p;
        p = '0;
        for (int i = 0; i < M; i++)
            if (b[i]) p = p ^ ({{(M-1){1'b0}}, a} << i);
        for (int i = 2*M-2; i >= M; i--)
            if (p[i]) p = p ^ ({{(M-2){1'b0}}, GF_POLY} << (i - M));
        return p[M-1:0];
    endfunction

    function automatic gf_t tb_pow(int e);
        gf_t r;
        gf_t b;
        int x;
        r = gf_t'(1);
        b = gf_t'(2);
        x = e % ORD;
        while (x > 0) begin
            if (x % 2 == 1) r = tb_mul(r, b);
            b = tb_mul(b, b);
            x = x / 2;
        end
        return r;
    endfunction

    function automatic int t_of(logic [1:0] md);
        return (md == 2'd0) ? 8 : (md == 2'd1) ? 16 : 32;
    endfunction

    task automatic build(input int nu, input int base, input int stp);
        synd = '0;
        for (int j = 0; j <= T_MAX; j++) ep[j] = '0;
        ep[0] = gf_t'(1);
        for (int e = 0; e < nu; e++) begin
            gf_t x;
            gf_t xi;
            x = tb_pow(base + e * stp);
            for (int j = T_MAX; j >= 1; j--) ep[j] = ep[j] ^ tb_mul(x, ep[j-1]);
            xi = x;
            for (int i = 1; i <= 2 * T_MAX; i++) begin
                synd[(i-1)*M +: M] = synd[(i-1)*M +: M] ^ xi;
                xi = tb_mul(xi, x);
            end
        end
    endtask

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_poly(input string tag);
        gf_t l0;
        int bad;
        l0 = lam[M-1:0];
        bad = -1;
        for (int j = 0; j <= T_MAX; j++)
            if (bad < 0 && lam[j*M +: M] != tb_mul(l0, ep[j])) bad = j;
        if (l0 == '0) check(1'b0, tag, 64'(l0), 64'd1);
        else if (bad >= 0) check(1'b0, tag, 64'(lam[bad*M +: M]), 64'(tb_mul(l0, ep[bad])));
        else check(1'b1, tag, 64'd0, 64'd0);
    endtask

    task automatic launch(input logic [1:0] md);
        @(negedge clk);
        mode = md;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (1) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (done) break;
            if (cyc > 2000) begin
                check(1'b0, "R3 done timeout", 64'(cyc), 64'd0);
                break;
            end
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
    endtask

    initial begin
        #(64'd200000 * 20);
        if (!finished) begin
            check(1'b0, "watchdog", 64'd0, 64'd1);
            summary();
            $finish;
        end
    end

    initial begin
        int cyc;
        logic [LW-1:0] held;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(done == 1'b0, "R1 done in reset", 64'(done), 64'd0);
        check(lam == LW'(1), "R1 lambda in reset", 64'(lam[63:0]), 64'd1);
        check(deg == '0, "R1 degree in reset", 64'(deg), 64'd0);
        rst = 1'b0;

        // table of vectors: R2 R3 R4 R5 R6
        for (int v = 0; v < 9; v++) begin
            logic [1:0] md;
            int nu;
            int tt;
            md = VEC[v][35:34];
            nu = int'(VEC[v][33:28]);
            tt = t_of(md);
            build(nu, int'(VEC[v][27:14]), int'(VEC[v][13:0]));
            launch(md);
            wait_done(cyc);
            check(cyc == tt, "R2 R3 latency equals t for mode", 64'(cyc), 64'(tt));
            check_poly("R4 locator polynomial");
            check(int'(deg) == nu, "R5 degree", 64'(deg), 64'(nu));
            if (tt < T_MAX) begin
                bit hz;
                hz = 1'b0;
                for (int j = tt + 1; j <= T_MAX; j++) if (lam[j*M +: M] != '0) hz = 1'b1;
                check(!hz, "R6 upper coefficients zero", 64'(hz), 64'd0);
            end
        end

        // R7: garbage in syndromes above 2t
        build(4, 50, 333);
        for (int i = 17; i <= 2 * T_MAX; i++) synd[(i-1)*M +: M] = M'(i * 37 + 677);
        launch(2'd0);
        wait_done(cyc);
        check_poly("R7 upper syndromes ignored");
        check(deg == DW'(4), "R7 degree with upper garbage", 64'(deg), 64'd4);

        // R8: start, mode and syndromes changed mid-run
        build(6, 20, 900);
        launch(2'd0);
        cyc = 0;
        for (int c = 1; c <= 60; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (c == 3) begin
                start = 1'b1;
                mode = 2'd2;
                synd = ~synd;
            end
            if (c == 4) start = 1'b0;
            if (done) begin
                cyc = c;
                break;
            end
        end
        check(cyc == 8, "R8 latency unaffected by mid-run start", 64'(cyc), 64'd8);
        check_poly("R8 result unaffected by mid-run inputs");

        // R9: start held across the final iteration edge
        build(8, 300, 700);
        launch(2'd0);
        cyc = 0;
        for (int c = 1; c <= 60; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (c == 7) start = 1'b1;
            if (done) begin
                cyc = c;
                start = 1'b0;
                break;
            end
        end
        check(cyc == 8, "R9 start on last iteration ignored", 64'(cyc), 64'd8);
        check_poly("R9 result with start on last iteration");
        held = lam;
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b1, "R9 done held", 64'(done), 64'd1);
        check(lam == held, "R9 lambda held", 64'(lam[63:0]), 64'(held[63:0]));

        // R9: restart while done
        build(2, 4000, 17);
        launch(2'd1);
        check(done == 1'b0, "R9 restart clears done", 64'(done), 64'd0);
        wait_done(cyc);
        check(cyc == 16, "R9 R3 restart latency", 64'(cyc), 64'd16);
        check_poly("R9 R4 restart result");

        // R1: reset while done
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b0, "R1 reset clears done", 64'(done), 64'd0);
        check(lam == LW'(1), "R1 reset restores lambda", 64'(lam[63:0]), 64'd1);
        rst = 1'b0;

        summary();
        $finish;
    end

endmodule